// File: doc/BRIEF.md
# Suspendable Stepped Erase Sequencer

This block runs a flash block erase as a series of loops. Each loop drives one erase pulse and then one verify pulse. The step level rises by one from each loop to the next. When a verify pulse reports the block erased, the erase ends with a done pulse. When the last allowed loop fails verify, the erase ends with a fail pulse. A pending read can interrupt the erase. Three policies, chosen at run time, decide how that happens:

- **abort** stops the current pulse after a short halt latency and later redoes that pulse from its start.
- **finish** lets the current loop run to its end and then parks.
- **guard** behaves like abort until the cycles spent halting or parked during this erase reach a limit. After that it behaves like finish until the erase ends.

All durations are parameters in clock cycles.

The state machine has eight states:

- `ST_IDLE`: no erase is active.
- `ST_HOST_RD`: a read is granted while no erase is active.
- `ST_PULSE`: the erase pulse is applied.
- `ST_CHECK`: the verify pulse is applied.
- `ST_HALTING`: the suspend latency after an abort.
- `ST_PARKED`: the erase is suspended and the read is granted.
- `ST_PASS`: the one-cycle done state.
- `ST_FAIL`: the one-cycle fail state.

The transitions are:

- **start**: `ST_IDLE` to `ST_PULSE`.
- **idle read**: `ST_IDLE` to `ST_HOST_RD`. The return from `ST_HOST_RD` to `ST_IDLE` happens on a read-complete with no new request.
- **pulse end**: `ST_PULSE` to `ST_CHECK`.
- **next loop**: `ST_CHECK` to `ST_PULSE`.
- **abort**: `ST_PULSE` or `ST_CHECK` to `ST_HALTING`.
- **halted**: `ST_HALTING` to `ST_PARKED`.
- **boundary park**: `ST_CHECK` to `ST_PARKED` at the end of a loop.
- **resume**: `ST_PARKED` to `ST_PULSE`.
- **pass**: `ST_CHECK` to `ST_PASS`.
- **exhaust**: `ST_CHECK` to `ST_FAIL`.
- **retire**: `ST_PASS` or `ST_FAIL` to `ST_IDLE`.

Top module: `erase_step_seq`

## Requirements
- R1: After reset, all outputs are low: the step level is 0 and the pulse kind is none (00).
- R2: After start, the pulse kind is erase (01) for ERS_CYC cycles and then verify (10) for VFY_CYC cycles. A new loop begins with step level one higher, starting from 0.
- R3: A verify result sampled high in the last verify cycle gives erase_done high for exactly one cycle on the next cycle, and the step level keeps the passing loop's value.
- R4: If loop MAX_LOOPS-1 fails verify, erase_fail pulses for one cycle with the step level at MAX_LOOPS-1.
- R5: Under abort policy (00), a read request during a pulse that is not at a loop end sets suspended at once with no grant. The grant follows after SUSP_CYC cycles. On resume, the same step level gets a full ERS_CYC erase pulse.
- R6: Under finish policy (01, and 11 alike), a read request does not stop the current loop. The block parks at the loop end with no halt latency, and resume starts the next loop at level+1.
- R7: The read grant is high only while parked or during an idle read. A read-complete that arrives while a request is still high keeps the grant for the next read.
- R8: Under guard policy (10), the block aborts until the accumulated halting plus parked cycles reach GUARD_LIM. guard_hit then stays high and reads are handled as under finish policy. Starting a new erase clears guard_hit.
- R9: A read request while no erase is active is granted on the next cycle.
- R10: erase_start is ignored while an erase is in progress; the step level and pulse continue unchanged.
- R11: At the last verify cycle, a pass or an exhausted loop count takes precedence over a pending read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_start | input | 1 | Starts an erase when idle |
| verify_pass | input | 1 | Block-erased indication, sampled at the last verify cycle |
| rd_req | input | 1 | A read is pending |
| rd_done | input | 1 | The granted read has completed |
| policy_sel | input | 2 | 00 abort, 01 finish, 10 guard, 11 finish |
| erase_done | output | 1 | One-cycle erase success |
| erase_fail | output | 1 | One-cycle erase failure |
| rd_grant | output | 1 | The array is free for the read |
| pulse_kind | output | 2 | 00 none, 01 erase pulse, 10 verify pulse |
| step_level | output | LVL_W | Current loop index, used as the erase level |
| suspended | output | 1 | Halting or parked |
| guard_hit | output | 1 | The suspended-time limit was reached in this erase |

## Verification
The assertions assume the following about the inputs:
- rd_done arrives only while the grant is high.
- A requester that has no further read drops rd_req in the same cycle it raises rd_done.
- erase_start is a single-cycle pulse.

The bench drives every input at the falling edge through tasks that follow these rules. Each task waits for the grant before it completes a read and lowers the request together with the completion. verify_pass is registered from the step level on the falling edge, so the value the block samples always belongs to the loop being verified.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_HOST_RD, ST_PULSE, ST_CHECK,
        ST_HALTING, ST_PARKED, ST_PASS, ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        POL_ABORT  = 2'b00,
        POL_FINISH = 2'b01,
        POL_GUARD  = 2'b10,
        POL_ALT    = 2'b11
    } policy_t;

    localparam logic [1:0] PK_NONE   = 2'b00;
    localparam logic [1:0] PK_ERASE  = 2'b01;
    localparam logic [1:0] PK_VERIFY = 2'b10;
endpackage

// File: rtl/erase_phase_timer.sv
module erase_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/erase_susp_accum.sv
module erase_susp_accum #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic reached
);
    localparam int AW = $clog2(LIMIT + 1);
    localparam logic [AW-1:0] LIM_V = AW'(LIMIT);

    logic [AW-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (inc && acc != LIM_V)
            acc <= acc + 1'b1;
    end

    assign reached = (acc == LIM_V);
endmodule

// File: rtl/erase_step_seq.sv
module erase_step_seq
    import erase_seq_pkg::*;
#(
    parameter int unsigned ERS_CYC   = 125000,
    parameter int unsigned VFY_CYC   = 12500,
    parameter int unsigned SUSP_CYC  = 12500,
    parameter int unsigned MAX_LOOPS = 8,
    parameter int unsigned GUARD_LIM = 8000000,
    localparam int LVL_W = (MAX_LOOPS > 1) ? $clog2(MAX_LOOPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase_start,
    input  logic             verify_pass,
    input  logic             rd_req,
    input  logic             rd_done,
    input  logic [1:0]       policy_sel,
    output logic             erase_done,
    output logic             erase_fail,
    output logic             rd_grant,
    output logic [1:0]       pulse_kind,
    output logic [LVL_W-1:0] step_level,
    output logic             suspended,
    output logic             guard_hit
);
    localparam int unsigned M1   = (ERS_CYC > VFY_CYC) ? ERS_CYC : VFY_CYC;
    localparam int unsigned TMAX = (M1 > SUSP_CYC) ? M1 : SUSP_CYC;
    localparam int TW = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_ERS  = TW'(ERS_CYC - 1);
    localparam logic [TW-1:0] T_VFY  = TW'(VFY_CYC - 1);
    localparam logic [TW-1:0] T_SUSP = TW'(SUSP_CYC - 1);
    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(MAX_LOOPS - 1);

    seq_state_t       st, nxt;
    logic             tload, tlast;
    logic [TW-1:0]    tval;
    logic             lvl_clr, lvl_inc, adv_set, adv_clr, adv_q;
    logic             acc_clr, abort_ok;
    logic [LVL_W-1:0] lvl_q;

    erase_phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .last(tlast)
    );

    erase_susp_accum #(.LIMIT(GUARD_LIM)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr),
        .inc(st == ST_HALTING || st == ST_PARKED), .reached(guard_hit)
    );

    always_comb begin
        unique case (policy_t'(policy_sel))
            POL_ABORT:  abort_ok = 1'b1;
            POL_GUARD:  abort_ok = !guard_hit;
            POL_FINISH,
            POL_ALT:    abort_ok = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = st; tload = 1'b0; tval = '0;
        lvl_clr = 1'b0; lvl_inc = 1'b0; adv_set = 1'b0; adv_clr = 1'b0; acc_clr = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (erase_start) begin
                    nxt = ST_PULSE; tload = 1'b1; tval = T_ERS;
                    lvl_clr = 1'b1; acc_clr = 1'b1;
                end else if (rd_req) begin
                    nxt = ST_HOST_RD;
                end
            end
            ST_HOST_RD: if (rd_done && !rd_req) nxt = ST_IDLE;
            ST_PULSE: begin
                if (rd_req && abort_ok) begin
                    nxt = ST_HALTING; tload = 1'b1; tval = T_SUSP; adv_clr = 1'b1;
                end else if (tlast) begin
                    nxt = ST_CHECK; tload = 1'b1; tval = T_VFY;
                end
            end
            ST_CHECK: begin
                if (tlast) begin
                    if (verify_pass) nxt = ST_PASS;
                    else if (lvl_q == LVL_TOP) nxt = ST_FAIL;
                    else if (rd_req) begin
                        nxt = ST_PARKED; adv_set = 1'b1;
                    end else begin
                        nxt = ST_PULSE; tload = 1'b1; tval = T_ERS; lvl_inc = 1'b1;
                    end
                end else if (rd_req && abort_ok) begin
                    nxt = ST_HALTING; tload = 1'b1; tval = T_SUSP; adv_clr = 1'b1;
                end
            end
            ST_HALTING: if (tlast) nxt = ST_PARKED;
            ST_PARKED: begin
                if (rd_done && !rd_req) begin
                    nxt = ST_PULSE; tload = 1'b1; tval = T_ERS; lvl_inc = adv_q;
                end
            end
            ST_PASS, ST_FAIL: nxt = ST_IDLE;
        endcase
    end

    // state register and loop bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            lvl_q <= '0;
            adv_q <= 1'b0;
        end else begin
            st <= nxt;
            if (lvl_clr)      lvl_q <= '0;
            else if (lvl_inc) lvl_q <= lvl_q + 1'b1;
            if (adv_set)      adv_q <= 1'b1;
            else if (adv_clr) adv_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        erase_done = 1'b0; erase_fail = 1'b0; rd_grant = 1'b0;
        pulse_kind = PK_NONE; suspended = 1'b0;
        unique case (st)
            ST_IDLE:    ;
            ST_HOST_RD: rd_grant = 1'b1;
            ST_PULSE:   pulse_kind = PK_ERASE;
            ST_CHECK:   pulse_kind = PK_VERIFY;
            ST_HALTING: suspended = 1'b1;
            ST_PARKED:  begin suspended = 1'b1; rd_grant = 1'b1; end
            ST_PASS:    erase_done = 1'b1;
            ST_FAIL:    erase_fail = 1'b1;
        endcase
    end

    assign step_level = lvl_q;
endmodule

// File: rtl/erase_step_seq_chk.sv
module erase_step_seq_chk #(
    parameter int unsigned MAX_LOOPS = 8,
    localparam int LVL_W = (MAX_LOOPS > 1) ? $clog2(MAX_LOOPS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             erase_start,
    input logic             verify_pass,
    input logic             erase_done,
    input logic             erase_fail,
    input logic             rd_grant,
    input logic [1:0]       pulse_kind,
    input logic [LVL_W-1:0] step_level,
    input logic             suspended,
    input logic             guard_hit
);
    assert_grant_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> (pulse_kind == 2'b00 && !erase_done && !erase_fail));

    assert_done_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> ($past(pulse_kind) == 2'b10 && $past(verify_pass)));

    assert_end_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_done && erase_fail));

    assert_fail_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fail |-> (step_level == LVL_W'(MAX_LOOPS - 1) && $past(pulse_kind) == 2'b10));

    assert_level_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_kind == 2'b01 && $past(pulse_kind) == 2'b10)
            |-> step_level == LVL_W'($past(step_level) + 1'b1));

    assert_parked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> pulse_kind == 2'b00);

    assert_guard_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(guard_hit) |-> $past(erase_start));
endmodule

bind erase_step_seq erase_step_seq_chk #(.MAX_LOOPS(MAX_LOOPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .erase_start(erase_start), .verify_pass(verify_pass),
    .erase_done(erase_done), .erase_fail(erase_fail), .rd_grant(rd_grant),
    .pulse_kind(pulse_kind), .step_level(step_level), .suspended(suspended),
    .guard_hit(guard_hit)
);

// File: tb/tb_erase_step_seq.sv
`timescale 1ns/1ps
module tb_erase_step_seq;
    localparam int ERS = 6, VFY = 3, SUSP = 2, MAXL = 5, LIM = 20;
    localparam int LW = $clog2(MAXL);

    logic clk = 1'b0, rst_n = 1'b0;
    logic erase_start = 0, verify_pass = 0, rd_req = 0, rd_done = 0;
    logic [1:0] policy_sel = 2'b00;
    logic erase_done, erase_fail, rd_grant, suspended, guard_hit;
    logic [1:0] pulse_kind;
    logic [LW-1:0] step_level;

    int n_chk = 0, n_err = 0, cyc = 0, pass_loop = 99;

    always #4 clk = ~clk;

    erase_step_seq #(.ERS_CYC(ERS), .VFY_CYC(VFY), .SUSP_CYC(SUSP),
                     .MAX_LOOPS(MAXL), .GUARD_LIM(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .erase_start(erase_start), .verify_pass(verify_pass),
        .rd_req(rd_req), .rd_done(rd_done), .policy_sel(policy_sel),
        .erase_done(erase_done), .erase_fail(erase_fail), .rd_grant(rd_grant),
        .pulse_kind(pulse_kind), .step_level(step_level), .suspended(suspended),
        .guard_hit(guard_hit));

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model: 0 idle,1 idle read,2 erase,3 verify,4 halting,5 parked,6 done,7 fail
    int m_st = 0, m_el = 0, m_lvl = 0, m_acc = 0;
    bit m_adv = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_el = 0; m_lvl = 0; m_acc = 0; m_adv = 0;
        end else begin
            bit imm;
            int old;
            imm = (policy_sel == 2'b00) || (policy_sel == 2'b10 && m_acc < LIM);
            old = m_st;
            if ((old == 4 || old == 5) && m_acc < LIM) m_acc++;
            case (old)
                0: if (erase_start) begin m_st = 2; m_el = 0; m_lvl = 0; m_acc = 0; end
                   else if (rd_req) m_st = 1;
                1: if (rd_done && !rd_req) m_st = 0;
                2: if (rd_req && imm) begin m_st = 4; m_el = 0; m_adv = 0; end
                   else if (m_el == ERS - 1) begin m_st = 3; m_el = 0; end
                   else m_el++;
                3: if (m_el == VFY - 1) begin
                       if (verify_pass) m_st = 6;
                       else if (m_lvl == MAXL - 1) m_st = 7;
                       else if (rd_req) begin m_st = 5; m_adv = 1; end
                       else begin m_st = 2; m_el = 0; m_lvl++; end
                   end else if (rd_req && imm) begin m_st = 4; m_el = 0; m_adv = 0; end
                   else m_el++;
                4: if (m_el == SUSP - 1) m_st = 5; else m_el++;
                5: if (rd_done && !rd_req) begin
                       m_st = 2; m_el = 0;
                       if (m_adv) m_lvl++;
                   end
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int ek;
            ek = (m_st == 2) ? 1 : (m_st == 3) ? 2 : 0;
            check(int'(pulse_kind) == ek, "R2 pulse_kind", pulse_kind, ek);
            check(int'(step_level) == m_lvl, "R2 step_level", step_level, m_lvl);
            check(erase_done == (m_st == 6), "R3 erase_done", erase_done, m_st == 6);
            check(erase_fail == (m_st == 7), "R4 erase_fail", erase_fail, m_st == 7);
            check(rd_grant == (m_st == 1 || m_st == 5), "R7 rd_grant", rd_grant, m_st == 1 || m_st == 5);
            check(suspended == (m_st == 4 || m_st == 5), "R5 suspended", suspended, m_st == 4 || m_st == 5);
            check(guard_hit == (m_acc >= LIM), "R8 guard_hit", guard_hit, m_acc >= LIM);
        end
        verify_pass <= (int'(step_level) == pass_loop);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic start_erase();
        erase_start = 1; tick(); erase_start = 0;
    endtask

    task automatic finish_erase();
        while (!erase_done && !erase_fail) tick();
        tick();
    endtask

    task automatic do_read(int hold);
        rd_req = 1;
        while (!rd_grant) tick();
        repeat (hold) tick();
        rd_done = 1; rd_req = 0; tick(); rd_done = 0;
    endtask

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1; tick();
        // R1 reset state
        check(pulse_kind == 0 && step_level == 0 && !rd_grant && !suspended &&
              !erase_done && !erase_fail && !guard_hit, "R1 reset outputs", pulse_kind, 0);

        // R9 idle read granted next cycle
        rd_req = 1; tick();
        check(rd_grant == 1, "R9 idle grant", rd_grant, 1);
        rd_done = 1; rd_req = 0; tick(); rd_done = 0;
        check(rd_grant == 0, "R9 idle release", rd_grant, 0);

        // R2/R3 plain erase passing on loop 2
        pass_loop = 2; policy_sel = 2'b00;
        start_erase();
        n = 0;
        while (!erase_done) begin n++; tick(); end
        check(n == 3 * (ERS + VFY), "R2 loop timing", n, 3 * (ERS + VFY));
        check(int'(step_level) == 2, "R3 done level", step_level, 2);
        tick();
        check(erase_done == 0, "R3 done single cycle", erase_done, 0);

        // R4 exhaustion
        pass_loop = 99;
        start_erase();
        while (!erase_fail) tick();
        check(int'(step_level) == MAXL - 1, "R4 fail level", step_level, MAXL - 1);
        tick();

        // R5 abort policy
        start_erase();
        while (!(step_level == 1 && pulse_kind == 1)) tick();
        tick(); tick();
        rd_req = 1; tick();
        check(suspended == 1 && rd_grant == 0, "R5 halting", suspended, 1);
        tick(); tick();
        check(rd_grant == 1, "R5 grant after latency", rd_grant, 1);
        rd_done = 1; rd_req = 0; tick(); rd_done = 0;
        check(int'(step_level) == 1, "R5 same level", step_level, 1);
        n = 0;
        while (pulse_kind == 1) begin n++; tick(); end
        check(n == ERS, "R5 full pulse redo", n, ERS);
        finish_erase();

        // R6 finish policy, R7 chained reads
        policy_sel = 2'b01;
        start_erase();
        tick();
        rd_req = 1; tick();
        check(suspended == 0 && pulse_kind == 1, "R6 loop continues", suspended, 0);
        while (!rd_grant) tick();
        check(int'(step_level) == 0, "R6 parked level", step_level, 0);
        rd_done = 1; rd_req = 1; tick(); rd_done = 0;
        check(rd_grant == 1, "R7 chained grant", rd_grant, 1);
        tick();
        rd_done = 1; rd_req = 0; tick(); rd_done = 0;
        check(pulse_kind == 1 && int'(step_level) == 1, "R6 next level resume", step_level, 1);
        // R10 start ignored while busy
        erase_start = 1; tick(); erase_start = 0;
        check(int'(step_level) == 1 && pulse_kind != 0, "R10 start ignored", step_level, 1);
        finish_erase();

        // R8 guard policy
        policy_sel = 2'b10;
        start_erase();
        n = 0;
        while (!guard_hit && n < 8) begin
            while (pulse_kind != 1) tick();
            do_read(6);
            n++;
        end
        check(guard_hit == 1, "R8 guard reached", guard_hit, 1);
        while (pulse_kind != 1) tick();
        rd_req = 1; tick();
        check(suspended == 0, "R8 deferred after guard", suspended, 0);
        while (!rd_grant) tick();
        rd_done = 1; rd_req = 0; tick(); rd_done = 0;
        finish_erase();
        start_erase();
        check(guard_hit == 0, "R8 guard cleared", guard_hit, 0);
        finish_erase();

        // R11 pass beats pending read
        policy_sel = 2'b01; pass_loop = 0;
        start_erase();
        while (pulse_kind != 2) tick();
        rd_req = 1;
        while (!erase_done && !rd_grant) tick();
        check(erase_done == 1, "R11 pass precedence", erase_done, 1);
        while (!rd_grant) tick();
        rd_done = 1; rd_req = 0; tick(); rd_done = 0;
        repeat (3) tick();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule